// File: doc/BRIEF.md
# PHY Interrupt Control Register

This block holds the three-bit interrupt control register of an Ethernet PHY's management register space and turns it into pin behaviour. The register sits at management address 0x11. Software can force an interrupt for as long as a self-test bit stays set, and it can open a global gate for event-driven interrupts. A neighbouring event-status block supplies the event flags and the per-event enable bits as two vectors. There are six event sources: energy-detect change, link change, speed change, duplex change, auto-negotiation complete, and a statistics counter reaching half full. This block ANDs each flag with its enable, ORs the results, gates them with the global bit and then registers one interrupt request.

The request leaves the chip on a pad that it shares with the power-down input. A register bit selects the pad's direction. In output mode the pad carries the request active low. In input mode the output driver is released, and the pad level passes through a synchronizer and comes out as an active-low power-down request. The register bus is a plain single-cycle bus with address, write strobe, write data and combinational read data. It has no handshake, so no back-pressure applies: every write and every read completes in the cycle it is presented.

Top module: `phy_irq_ctrl`

## Requirements
- R1: The reset is synchronous and active high. After reset the register at address 0x11 reads 0x0000, irq_req is 0, pad_oe is 0, pad_out_n is 1 and power_down_n is 1.
- R2: A write to address 0x11 stores write-data bits 2:0. Bits 15:3 are ignored and always read back as 0, so writing 0xFFFF reads back 0x0007.
- R3: A read from any address other than 0x11 returns 0x0000. A write to any other address leaves the register unchanged.
- R4: While bit 0 (test) is 1, irq_req is 1 regardless of the events and of bit 1. Clearing bit 0 with no other source active drops irq_req one clock after the write.
- R5: When bit 1 (global event enable) is 0, no event can raise irq_req. When bit 1 is 1, any event whose flag and enable are both 1 raises irq_req.
- R6: Each of the six event lanes i contributes only when evt_flag[i] and evt_en[i] are both 1. A flag whose own enable is 0 has no effect.
- R7: irq_req is registered. It reflects the register and event inputs one clock after they change: one clock after a register write completes, and one clock after an event input changes.
- R8: pad_oe equals bit 2. While bit 2 is 1, pad_out_n is the inverse of irq_req. While bit 2 is 0, pad_out_n is held at 1.
- R9: While bit 2 is 0, power_down_n follows pad_in after two clocks of synchronization. While bit 2 is 1, power_down_n is forced to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 5 | Management register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| evt_flag | input | 6 | Latched event flags from the event-status block |
| evt_en | input | 6 | Per-event enables from the event-status block |
| irq_req | output | 1 | Registered interrupt request, active high |
| pad_oe | output | 1 | Output enable for the shared pad driver |
| pad_out_n | output | 1 | Value driven onto the pad, active-low interrupt |
| pad_in | input | 1 | Sampled level of the shared pad |
| power_down_n | output | 1 | Synchronized power-down request, active low |

## Verification
The bench builds the block with its defaults: a 5-bit address with the register at 0x11, six event lanes and two synchronizer stages. Having six lanes lets the bench drive each lane alone, once with only its own enable cleared and once with only its own enable set. With two stages the bench can check the exact clock on which a pad change reaches power_down_n, including the intermediate clock on which the old value must still be present.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int CTRL_BITS = 3;

  typedef struct packed {
    logic out_en;   // bit 2: pad drives interrupt
    logic evt_en;   // bit 1: global event gate
    logic test;     // bit 0: forced interrupt
  } irq_ctrl_t;
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import phy_irq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int REG_ADDR = 'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output irq_ctrl_t         ctrl
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic hit;
  logic unused_wdata;

  assign hit          = (bus_addr == HIT_ADDR);
  assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_BITS];

  always_ff @(posedge clk) begin
    if (rst)
      ctrl <= '0;
    else if (bus_wr && hit)
      ctrl <= irq_ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
  end

  always_comb begin
    bus_rdata = '0;
    if (hit)
      bus_rdata[CTRL_BITS-1:0] = ctrl;
  end

  // R2
  write_store_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit) |=> (ctrl == $past(bus_wdata[CTRL_BITS-1:0])));

  // R3
  foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit) |=> $stable(ctrl));
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import phy_irq_pkg::*;
#(
  parameter int NUM_EVT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  irq_ctrl_t          ctrl,
  input  logic [NUM_EVT-1:0] evt_flag,
  input  logic [NUM_EVT-1:0] evt_en,
  output logic               irq_q
);
  logic [NUM_EVT-1:0] lane_hit;
  logic               any_evt;
  logic               irq_d;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_lane
    assign lane_hit[i] = evt_flag[i] & evt_en[i];
  end

  assign any_evt = |lane_hit;
  assign irq_d   = ctrl.test | (ctrl.evt_en & any_evt);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_d;
  end

  // R4
  test_forces_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.test |=> irq_q);

  // R5
  gate_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.test && !ctrl.evt_en) |=> !irq_q);

  // R6
  lane_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.test && ((evt_flag & evt_en) == '0)) |=> !irq_q);
endmodule

// File: rtl/pad_ctrl.sv
module pad_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic out_en,
  input  logic irq_q,
  input  logic pad_in,
  output logic pad_oe,
  output logic pad_out_n,
  output logic power_down_n
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
  end

  assign pad_oe       = out_en;
  assign pad_out_n    = out_en ? ~irq_q : 1'b1;
  assign power_down_n = out_en ? 1'b1 : sync_q[LAST];

  // R8
  parked_high_chk: assert property (@(posedge clk) disable iff (rst)
    !pad_oe |-> pad_out_n);

  // R9
  pd_forced_chk: assert property (@(posedge clk) disable iff (rst)
    pad_oe |-> power_down_n);
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int REG_ADDR    = 'h11,
  parameter int NUM_EVT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] evt_flag,
  input  logic [NUM_EVT-1:0] evt_en,
  output logic               irq_req,
  output logic               pad_oe,
  output logic               pad_out_n,
  input  logic               pad_in,
  output logic               power_down_n
);
  irq_ctrl_t ctrl;
  logic      irq_q;

  irq_ctl_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ctrl     (ctrl)
  );

  irq_combine #(
    .NUM_EVT(NUM_EVT)
  ) u_comb (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .evt_flag(evt_flag),
    .evt_en  (evt_en),
    .irq_q   (irq_q)
  );

  pad_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pad (
    .clk         (clk),
    .rst         (rst),
    .out_en      (ctrl.out_en),
    .irq_q       (irq_q),
    .pad_in      (pad_in),
    .pad_oe      (pad_oe),
    .pad_out_n   (pad_out_n),
    .power_down_n(power_down_n)
  );

  assign irq_req = irq_q;

  // R8
  pad_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    pad_oe |-> (pad_out_n == !irq_req));
endmodule

// File: tb/sim_phy_irq_ctrl.sv
module sim_phy_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [5:0]  evt_flag = '0;
  logic [5:0]  evt_en = '0;
  logic        irq_req, pad_oe, pad_out_n, power_down_n;
  logic        pad_in = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  phy_irq_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_flag(evt_flag),
    .evt_en(evt_en), .irq_req(irq_req), .pad_oe(pad_oe),
    .pad_out_n(pad_out_n), .pad_in(pad_in), .power_down_n(power_down_n)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 5'h11;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(5'h11, v);
    chk("R1 reg", v, 16'h0000);
    chk("R1 irq", {15'b0, irq_req}, 16'h0);
    chk("R1 oe", {15'b0, pad_oe}, 16'h0);
    chk("R1 pad", {15'b0, pad_out_n}, 16'h1);
    chk("R1 pd", {15'b0, power_down_n}, 16'h1);
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    wr(5'h11, 16'hFFFF);
    rd(5'h11, v);
    chk("R2 readback", v, 16'h0007);
    wr(5'h11, 16'hFFF8);
    rd(5'h11, v);
    chk("R2 reserved only", v, 16'h0000);
  endtask

  task automatic t_other_addr();
    logic [15:0] v;
    wr(5'h11, 16'h0002);
    wr(5'h10, 16'h0005);
    rd(5'h11, v);
    chk("R3 foreign write", v, 16'h0002);
    rd(5'h12, v);
    chk("R3 foreign read", v, 16'h0000);
    rd(5'h01, v);
    chk("R3 foreign read 2", v, 16'h0000);
    wr(5'h11, 16'h0000);
  endtask

  task automatic t_test_irq();
    evt_flag = '0; evt_en = '0;
    wr(5'h11, 16'h0001);
    chk("R7 not yet", {15'b0, irq_req}, 16'h0);
    @(negedge clk);
    chk("R4 forced", {15'b0, irq_req}, 16'h1);
    repeat (3) @(negedge clk);
    chk("R4 held", {15'b0, irq_req}, 16'h1);
    wr(5'h11, 16'h0000);
    chk("R7 still high", {15'b0, irq_req}, 16'h1);
    @(negedge clk);
    chk("R4 cleared", {15'b0, irq_req}, 16'h0);
  endtask

  task automatic t_global_enable();
    evt_flag = 6'b000100; evt_en = 6'b000100;
    wr(5'h11, 16'h0000);
    @(negedge clk);
    chk("R5 blocked", {15'b0, irq_req}, 16'h0);
    wr(5'h11, 16'h0002);
    @(negedge clk);
    chk("R5 passed", {15'b0, irq_req}, 16'h1);
    evt_flag = '0;
    @(negedge clk);
    chk("R7 event drop", {15'b0, irq_req}, 16'h0);
    wr(5'h11, 16'h0000);
  endtask

  task automatic t_per_event();
    wr(5'h11, 16'h0006);
    for (int i = 0; i < 6; i++) begin
      evt_flag = 6'(1 << i); evt_en = ~6'(1 << i);
      @(negedge clk);
      chk($sformatf("R6 lane %0d masked", i), {15'b0, irq_req}, 16'h0);
      evt_en = 6'(1 << i);
      @(negedge clk);
      chk($sformatf("R6 lane %0d live", i), {15'b0, irq_req}, 16'h1);
      chk($sformatf("R8 lane %0d pad", i), {15'b0, pad_out_n}, 16'h0);
    end
    evt_flag = '0; evt_en = '0;
    @(negedge clk);
    chk("R8 pad idle", {15'b0, pad_out_n}, 16'h1);
  endtask

  task automatic t_pad_mode();
    wr(5'h11, 16'h0001);
    @(negedge clk);
    chk("R8 oe off", {15'b0, pad_oe}, 16'h0);
    chk("R8 parked", {15'b0, pad_out_n}, 16'h1);
    wr(5'h11, 16'h0005);
    chk("R8 oe on", {15'b0, pad_oe}, 16'h1);
    chk("R8 driving", {15'b0, pad_out_n}, 16'h0);
    wr(5'h11, 16'h0000);
    @(negedge clk);
  endtask

  task automatic t_power_down();
    pad_in = 1'b0;
    @(negedge clk);
    chk("R9 one stage", {15'b0, power_down_n}, 16'h1);
    @(negedge clk);
    chk("R9 two stages", {15'b0, power_down_n}, 16'h0);
    wr(5'h11, 16'h0004);
    chk("R9 forced", {15'b0, power_down_n}, 16'h1);
    wr(5'h11, 16'h0000);
    chk("R9 back", {15'b0, power_down_n}, 16'h0);
    pad_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 release", {15'b0, power_down_n}, 16'h1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    bus_addr = 5'h11;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_other_addr();
    t_test_irq();
    t_global_enable();
    t_per_event();
    t_pad_mode();
    t_power_down();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule